// File: doc/BRIEF.md
# Working Set Reference History Tracker

This block follows which memory pages a process has touched recently. Every page has a live reference flag, which a reference event sets, and a short shift register of older flags. An interval timer with a run-time programmable period produces a sampling strobe. On each strobe, every page's live flag moves into the youngest slot of its history, the oldest slot is dropped, and the live flag is cleared.

A page counts as part of the working set while its live flag or any of its history slots is set. Software-side logic can query one page at a time and read a running count of member pages. The history depth sets the width of the window in timer intervals. More slots with a shorter period give finer timing within the same window.

Top module: `ws_tracker`

## Requirements
- R1: After a synchronous active-low reset, every live flag and history slot is clear, `ws_size` is 0, `in_set` is 0 for every page, and the timer period equals `DEFAULT_PERIOD`.
- R2: With period P (P ≥ 1), `sample_strobe` is high for one cycle in every P cycles. The first strobe comes in the P-th cycle after reset or after a period write. A period value of 0 behaves as 1, so the strobe is high every cycle.
- R3: In the cycle `period_wr` is high, the new period is stored, the interval count restarts from zero, and no strobe or shift happens in that cycle.
- R4: A reference event (`ref_valid` high with page index `ref_page`) outside a strobe cycle sets that page's live flag. The page reads as a member from the next cycle on.
- R5: On a strobe, each page's history shifts by one slot. The live flag enters slot 0 and the oldest slot is discarded. The live flag is then cleared.
- R6: A reference event in the same cycle as a strobe is not lost. The referenced page's live flag is set after that edge, while its old live value still enters the history.
- R7: `in_set` for `query_page` is the OR of that page's live flag and all its history slots, with no added latency. A page referenced once and then left alone leaves the set at the (HIST_BITS+1)-th strobe after the reference.
- R8: `ws_size` equals the number of member pages as they stood one cycle earlier. It is a register updated one cycle after each shift or reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_valid | input | 1 | Reference event strobe |
| ref_page | input | PAGE_W | Page index of the reference |
| period_wr | input | 1 | Write enable for the timer period |
| period_data | input | PERIOD_W | New timer period in cycles |
| query_page | input | PAGE_W | Page index to look up |
| in_set | output | 1 | Working-set membership of `query_page` |
| ws_size | output | CNT_W | Number of member pages (one-cycle lag) |
| sample_strobe | output | 1 | High in the cycle a history shift occurs |

## Verification
The hardest case to reach is a reference that lands exactly in the strobe cycle. From the ports it looks like any other reference, yet it must survive the clear of the live flag. The stimulus tracks the interval count in the bench model and fires the reference only in the cycle the model predicts a strobe, then queries that page across the following shifts. A zero-period phase puts a strobe in every cycle, so every reference in that phase collides with a shift.

// File: rtl/ws_pkg.sv
// Package: shared helpers for the working-set tracker.
// Assumes periods are unsigned; a zero period is clamped to one.
package ws_pkg;

    // Clamp a period value so that zero behaves as one cycle.
    function automatic logic [31:0] clamp_period(input logic [31:0] p);
        return (p == 32'd0) ? 32'd1 : p;
    endfunction

endpackage

// File: rtl/ws_interval_timer.sv
// Module: interval timer that raises a one-cycle fire pulse every
// programmed number of cycles. A period write restarts the count and
// suppresses firing in the write cycle. Assumes period 0 means 1.
module ws_interval_timer #(
    parameter int PERIOD_W       = 16,
    parameter int DEFAULT_PERIOD = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PERIOD_W-1:0] wr_data,
    output logic                fire
);
    import ws_pkg::*;

    logic [PERIOD_W-1:0] period_q;
    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] eff;
    logic [31:0]         eff_wide;
    logic                at_end;

    // Effective period and end-of-interval detect.
    always_comb begin
        eff_wide = clamp_period(32'(period_q));
        eff      = eff_wide[PERIOD_W-1:0];
        at_end   = (cnt_q == eff - 1'b1);
        fire     = at_end && !wr_en;
    end

    // Period register and interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= PERIOD_W'(DEFAULT_PERIOD);
            cnt_q    <= '0;
        end else if (wr_en) begin
            period_q <= wr_data;
            cnt_q    <= '0;
        end else if (at_end) begin
            cnt_q    <= '0;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_q == '0));
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cnt_q == '0));
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < eff);

endmodule

// File: rtl/ws_page_slot.sv
// Module: per-page live reference flag plus a history shift register.
// On fire the live flag shifts into slot 0 and is reloaded with the
// same-cycle hit; otherwise a hit sets the live flag. Assumes HIST_BITS>=1.
module ws_page_slot #(
    parameter int HIST_BITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic hit,
    output logic member
);
    logic                 ref_q;
    logic [HIST_BITS-1:0] hist_q;
    logic [HIST_BITS-1:0] hist_next;

    // Next history value: drop oldest, take live flag into slot 0.
    generate
        if (HIST_BITS == 1) begin : g_one
            always_comb hist_next = ref_q;
        end else begin : g_many
            always_comb hist_next = {hist_q[HIST_BITS-2:0], ref_q};
        end
    endgenerate

    // Live flag and history update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= 1'b0;
            hist_q <= '0;
        end else if (fire) begin
            hist_q <= hist_next;
            ref_q  <= hit;
        end else begin
            ref_q  <= ref_q | hit;
        end
    end

    // Membership from live flag and any history slot.
    always_comb member = ref_q | (|hist_q);

    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !fire) |=> ref_q);
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !hit) |=> !ref_q);
    p_shift_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (hist_q[0] == $past(ref_q)));
    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && hit) |=> ref_q);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(hist_q));

endmodule

// File: rtl/ws_popcount.sv
// Module: registered population count of the membership vector.
// Output lags the vector by one cycle. Assumes CNT_W holds N.
module ws_popcount #(
    parameter int N     = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     vec,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] sum;

    // Combinational sum of set bits.
    always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++) begin
            sum = sum + CNT_W'(vec[i]);
        end
    end

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= sum;
    end

    p_size_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (32'(count) == $countones($past(vec))));
    p_size_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count) <= N);

endmodule

// File: rtl/ws_tracker.sv
// Module: top of the working-set tracker. Decodes reference events to
// pages, runs the interval timer, keeps per-page history and reports
// membership and size. Assumes NUM_PAGES >= 2.
module ws_tracker #(
    parameter int NUM_PAGES      = 16,
    parameter int HIST_BITS      = 2,
    parameter int PERIOD_W       = 16,
    parameter int DEFAULT_PERIOD = 20,
    localparam int PAGE_W        = $clog2(NUM_PAGES),
    localparam int CNT_W         = $clog2(NUM_PAGES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_valid,
    input  logic [PAGE_W-1:0]   ref_page,
    input  logic                period_wr,
    input  logic [PERIOD_W-1:0] period_data,
    input  logic [PAGE_W-1:0]   query_page,
    output logic                in_set,
    output logic [CNT_W-1:0]    ws_size,
    output logic                sample_strobe
);
    logic                 fire;
    logic [NUM_PAGES-1:0] member_vec;

    ws_interval_timer #(
        .PERIOD_W       (PERIOD_W),
        .DEFAULT_PERIOD (DEFAULT_PERIOD)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (period_wr),
        .wr_data (period_data),
        .fire    (fire)
    );

    generate
        for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
            logic hit;
            // Decode whether this page is the referenced one.
            always_comb hit = ref_valid && (32'(ref_page) == p);
            ws_page_slot #(
                .HIST_BITS (HIST_BITS)
            ) u_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .fire   (fire),
                .hit    (hit),
                .member (member_vec[p])
            );
        end
    endgenerate

    ws_popcount #(
        .N     (NUM_PAGES),
        .CNT_W (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .vec   (member_vec),
        .count (ws_size)
    );

    // Membership lookup for the queried page; out-of-range reads 0.
    always_comb begin
        in_set = 1'b0;
        if (32'(query_page) < NUM_PAGES) in_set = member_vec[query_page];
    end

    // Expose the shift strobe.
    always_comb sample_strobe = fire;

    p_no_shift_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        period_wr |-> !sample_strobe);

endmodule

// File: tb/ws_tracker_tb.sv
`timescale 1ns/1ps
module ws_tracker_tb;
    localparam int N    = 16;
    localparam int H    = 2;
    localparam int PW   = 16;
    localparam int DEF  = 20;
    localparam int PGW  = $clog2(N);
    localparam int CW   = $clog2(N + 1);

    logic           clk = 1'b0;
    logic           rst_n;
    logic           ref_valid;
    logic [PGW-1:0] ref_page;
    logic           period_wr;
    logic [PW-1:0]  period_data;
    logic [PGW-1:0] query_page;
    logic           in_set;
    logic [CW-1:0]  ws_size;
    logic           sample_strobe;

    always #2.5 clk = ~clk;

    ws_tracker #(
        .NUM_PAGES      (N),
        .HIST_BITS      (H),
        .PERIOD_W       (PW),
        .DEFAULT_PERIOD (DEF)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ref_valid     (ref_valid),
        .ref_page      (ref_page),
        .period_wr     (period_wr),
        .period_data   (period_data),
        .query_page    (query_page),
        .in_set        (in_set),
        .ws_size       (ws_size),
        .sample_strobe (sample_strobe)
    );

    // Reference model state, built from the requirements.
    int m_period, m_cnt, m_size;
    int m_ref  [N];
    int m_hist [N];

    function automatic int m_eff();
        return (m_period == 0) ? 1 : m_period;
    endfunction
    function automatic int m_member(int p);
        return (m_ref[p] != 0 || m_hist[p] != 0) ? 1 : 0;
    endfunction

    // Model update at each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_period = DEF; m_cnt = 0; m_size = 0;
            for (int p = 0; p < N; p++) begin m_ref[p] = 0; m_hist[p] = 0; end
        end else begin
            int sz;
            int fire;
            sz = 0;
            for (int p = 0; p < N; p++) sz += m_member(p);
            fire = (m_cnt == m_eff() - 1 && !period_wr) ? 1 : 0;
            for (int p = 0; p < N; p++) begin
                int hit;
                hit = (ref_valid && int'(ref_page) == p) ? 1 : 0;
                if (fire != 0) begin
                    m_hist[p] = ((m_hist[p] << 1) | m_ref[p]) & ((1 << H) - 1);
                    m_ref[p]  = hit;
                end else if (hit != 0) begin
                    m_ref[p] = 1;
                end
            end
            if (period_wr) begin m_period = int'(period_data); m_cnt = 0; end
            else if (fire != 0) m_cnt = 0;
            else m_cnt++;
            m_size = sz;
        end
    end

    // Scoreboard items.
    typedef struct {
        int    kind;   // 0 strobe, 1 in_set, 2 ws_size
        int    exp;
        string tag;
    } item_t;
    item_t sb_q[$];
    int total = 0, bad = 0;
    bit done = 0;

    // Monitor: pop and compare after inputs settle.
    always @(negedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            item_t it;
            int act;
            it = sb_q.pop_front();
            case (it.kind)
                0: act = int'(sample_strobe);
                1: act = int'(in_set);
                default: act = int'(ws_size);
            endcase
            total++;
            if (act != it.exp) begin
                bad++;
                $display("FAIL %s kind=%0d actual=%0d expected=%0d at %0t",
                         it.tag, it.kind, act, it.exp, $time);
            end
        end
    end

    // Driver: apply one cycle of stimulus and push expectations.
    task automatic step(input bit rv, input int rp, input bit pw, input int pd,
                        input int qp, input string tag);
        item_t it;
        @(negedge clk);
        ref_valid   = rv;
        ref_page    = PGW'(rp);
        period_wr   = pw;
        period_data = PW'(pd);
        query_page  = PGW'(qp);
        #1;
        it.kind = 0;
        it.exp  = (m_cnt == m_eff() - 1 && !pw) ? 1 : 0;
        it.tag  = {"R2 strobe / ", tag};
        sb_q.push_back(it);
        it.kind = 1; it.exp = m_member(qp); it.tag = {"R7 in_set / ", tag};
        sb_q.push_back(it);
        it.kind = 2; it.exp = m_size; it.tag = {"R8 size / ", tag};
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n, input int qp, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, qp, tag);
    endtask

    initial begin
        rst_n = 1'b0; ref_valid = 0; ref_page = '0; period_wr = 0;
        period_data = '0; query_page = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, queries across pages
        for (int p = 0; p < N; p++) step(0, 0, 0, 0, p, "R1 reset");
        // R2: default period strobes
        idle(30, 0, "R2 default period");
        // R3: period write restarts the interval
        step(0, 0, 1, 8, 0, "R3 period write");
        idle(20, 0, "R3 after write");
        // R4: references set live flags
        step(1, 3, 0, 0, 3, "R4 ref page 3");
        step(1, 5, 0, 0, 3, "R4 ref page 5");
        step(0, 0, 0, 0, 5, "R4 query page 5");
        // R5 / R7: aging of page 3 across several strobes
        idle(40, 3, "R5 aging page 3");
        // R6: reference lands on a strobe cycle
        while (m_cnt != m_eff() - 1) step(0, 0, 0, 0, 9, "R6 wait");
        step(1, 9, 0, 0, 9, "R6 ref on strobe");
        idle(28, 9, "R6 after coincident ref");
        // R2 zero period: strobe every cycle, references collide
        step(0, 0, 1, 0, 0, "R2 write zero");
        for (int i = 0; i < 10; i++) step(1, i, 0, 0, i, "R2 zero period");
        // R7 mixed pattern with short period
        step(0, 0, 1, 3, 0, "R3 write 3");
        for (int i = 0; i < 60; i++)
            step((i % 3) != 2, (i * 7) % N, 0, 0, (i * 5) % N, "R7 mixed");
        idle(15, 1, "R7 drain");
        @(negedge clk); #3;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule